// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

This block is a memory-mapped general purpose I/O port with a parameterised number of lines (1 to 32) and a small number of shared interrupt wires. Software reads the synchronised pad levels, sets the values driven onto the pads, and chooses per line whether the pad is driven. Every line also has a trigger selection: a polarity bit and an edge bit together pick one of four trigger kinds. An interrupt-enable bit gates the line, and a one-byte routing entry sends the line to one of the interrupt wires or to none.

The bus is a plain single-cycle register port. A write happens on the clock edge where `bus_we` is high. A read is combinational from `bus_addr`. Only word-aligned addresses (low two bits zero) decode. Pad inputs pass through a two-flop synchroniser. One more register holds the previous synchronised sample, and the edge detector uses it. Each line's trigger decode is a four-state selector: LVL_LOW, LVL_HIGH, EDGE_FALL and EDGE_RISE, chosen by {edge, polarity}. It moves between states only when software rewrites those two bits. Each interrupt wire is the OR of the enabled events of all lines routed to it.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the direction, output, enable, polarity and edge registers read 0, `pad_oe` and `pad_out` are 0, no interrupt wire is high, and every routing byte reads 0x80 (unrouted).
- R2: The registers at 0x04 (output), 0x08 (direction), 0x0C (enable), 0x10 (polarity), 0x14 (edge) and 0x18 (hold) read back the written value in bits N_LINES-1:0. Higher bits read 0.
- R3: `pad_oe` equals the direction register (1 = driven) and `pad_out` equals the output register, from the cycle after the write.
- R4: Address 0x00 returns the pad levels, which appear two clock edges after they change. Writes to 0x00 have no effect.
- R5: With polarity 0 and edge 0, an enabled line holds its interrupt high while its synchronised input is 0.
- R6: With polarity 1 and edge 0, an enabled line holds its interrupt high while its synchronised input is 1.
- R7: With edge 1, an enabled line gives a one-cycle pulse on the cycle its synchronised input changes. The edge must be a rise (0 to 1) when polarity is 1, or a fall (1 to 0) when polarity is 0. Nothing happens when the input is steady.
- R8: A line whose enable bit is 0 never raises any interrupt wire.
- R9: Routing starts at 0x20 with one byte per line and four lines per word: line i is in word 0x20+4*(i/4), bits 8*(i%4)+7 down to 8*(i%4). In each byte, bit 7 = 1 means unrouted, and bits 4:0 give the wire index. Bits 6:5 read 0. An index of N_IRQ or above routes nowhere. Each wire is the OR of the events of the lines routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | N_LINES | Pad input levels (asynchronous) |
| pad_out | output | N_LINES | Value driven onto each pad |
| pad_oe | output | N_LINES | Pad drive enable, 1 = driven |
| irq_o | output | N_IRQ | Shared interrupt wires |

## Verification
The hardest case to reach from the ports has three parts at once. Several lines share a wire. Those lines have different trigger kinds. Their pad transitions land in the same cycle, so a level line and an edge pulse overlap on one wire for exactly one cycle. The stimulus reaches this with random configurations: random trigger bits, random enables and random routing bytes, including unrouted and out-of-range indices. Each configuration is followed by a settled input word and then a random second word. The wires are compared in the pulse cycle and again one cycle later, against a bench function of the old and new pad words.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    // trigger kind of a line, encoded as {edge, polarity}
    typedef enum logic [1:0] {
        TRG_LVL_LOW   = 2'b00,
        TRG_LVL_HIGH  = 2'b01,
        TRG_EDGE_FALL = 2'b10,
        TRG_EDGE_RISE = 2'b11
    } trig_e;

    // word indices (byte offset / 4)
    localparam int unsigned W_IN     = 0;
    localparam int unsigned W_OUT    = 1;
    localparam int unsigned W_DIR    = 2;
    localparam int unsigned W_MASK   = 3;
    localparam int unsigned W_POL    = 4;
    localparam int unsigned W_EDGE   = 5;
    localparam int unsigned W_HOLD   = 6;
    localparam int unsigned W_ROUTE0 = 8;

    localparam int unsigned ROUTE_IDX_W = 5;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] now_o,
    output logic [WIDTH-1:0] old_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [WIDTH-1:0] stage3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            stage3_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
            stage3_q <= stage2_q;
        end
    end

    assign now_o = stage2_q;
    assign old_o = stage3_q;
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] now_i,
    input  logic [WIDTH-1:0] old_i,
    input  logic [WIDTH-1:0] enable_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic [WIDTH-1:0] edge_i,
    output logic [WIDTH-1:0] evt_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        trig_e kind;
        logic  hit;
        assign kind = trig_e'({edge_i[i], pol_i[i]});
        always_comb begin
            unique case (kind)
                TRG_LVL_LOW:   hit = ~now_i[i];
                TRG_LVL_HIGH:  hit = now_i[i];
                TRG_EDGE_FALL: hit = old_i[i] & ~now_i[i];
                TRG_EDGE_RISE: hit = ~old_i[i] & now_i[i];
                default:       hit = 1'b0;
            endcase
        end
        assign evt_o[i] = enable_i[i] & hit;
    end
endmodule

// File: rtl/gpio_irq_router.sv
`timescale 1ns/1ps
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned N_IRQ   = 4
) (
    input  logic [N_LINES-1:0]             evt_i,
    input  logic [N_LINES-1:0]             off_i,
    input  logic [N_LINES*ROUTE_IDX_W-1:0] idx_i,
    output logic [N_IRQ-1:0]               irq_o
);
    for (genvar j = 0; j < N_IRQ; j++) begin : g_wire
        logic [N_LINES-1:0] sel;
        for (genvar i = 0; i < N_LINES; i++) begin : g_sel
            assign sel[i] = ~off_i[i] &&
                (idx_i[i*ROUTE_IDX_W +: ROUTE_IDX_W] == ROUTE_IDX_W'(j));
        end
        assign irq_o[j] = |(evt_i & sel);
    end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned N_IRQ   = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] pad_in,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_oe,
    output logic [N_IRQ-1:0]   irq_o
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [N_LINES-1:0] out_q, dir_q, mask_q, pol_q, edge_q, hold_q;
    logic [N_LINES-1:0] route_off;
    logic [ROUTE_IDX_W-1:0] route_idx [N_LINES];
    logic [N_LINES*ROUTE_IDX_W-1:0] route_idx_flat;
    logic [N_LINES-1:0] sync_now, sync_old, line_evt;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            dir_q     <= '0;
            mask_q    <= '0;
            pol_q     <= '0;
            edge_q    <= '0;
            hold_q    <= '0;
            route_off <= '1;
            for (int i = 0; i < N_LINES; i++) route_idx[i] <= '0;
        end else if (bus_we && aligned) begin
            if (widx == WIDX_W'(W_OUT))  out_q  <= bus_wdata[N_LINES-1:0];
            if (widx == WIDX_W'(W_DIR))  dir_q  <= bus_wdata[N_LINES-1:0];
            if (widx == WIDX_W'(W_MASK)) mask_q <= bus_wdata[N_LINES-1:0];
            if (widx == WIDX_W'(W_POL))  pol_q  <= bus_wdata[N_LINES-1:0];
            if (widx == WIDX_W'(W_EDGE)) edge_q <= bus_wdata[N_LINES-1:0];
            if (widx == WIDX_W'(W_HOLD)) hold_q <= bus_wdata[N_LINES-1:0];
            for (int i = 0; i < N_LINES; i++) begin
                if (widx == WIDX_W'(W_ROUTE0 + i / 4)) begin
                    route_off[i] <= bus_wdata[8*(i%4) + 7];
                    route_idx[i] <= bus_wdata[8*(i%4) +: ROUTE_IDX_W];
                end
            end
        end
    end

    // register reads
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == WIDX_W'(W_IN))   bus_rdata[N_LINES-1:0] = sync_now;
            if (widx == WIDX_W'(W_OUT))  bus_rdata[N_LINES-1:0] = out_q;
            if (widx == WIDX_W'(W_DIR))  bus_rdata[N_LINES-1:0] = dir_q;
            if (widx == WIDX_W'(W_MASK)) bus_rdata[N_LINES-1:0] = mask_q;
            if (widx == WIDX_W'(W_POL))  bus_rdata[N_LINES-1:0] = pol_q;
            if (widx == WIDX_W'(W_EDGE)) bus_rdata[N_LINES-1:0] = edge_q;
            if (widx == WIDX_W'(W_HOLD)) bus_rdata[N_LINES-1:0] = hold_q;
            for (int i = 0; i < N_LINES; i++) begin
                if (widx == WIDX_W'(W_ROUTE0 + i / 4))
                    bus_rdata[8*(i%4) +: 8] = {route_off[i], 2'b00, route_idx[i]};
            end
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_flat
        assign route_idx_flat[i*ROUTE_IDX_W +: ROUTE_IDX_W] = route_idx[i];
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    gpio_in_sync #(.WIDTH(N_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .now_o (sync_now),
        .old_o (sync_old)
    );

    gpio_trig_detect #(.WIDTH(N_LINES)) u_detect (
        .now_i    (sync_now),
        .old_i    (sync_old),
        .enable_i (mask_q),
        .pol_i    (pol_q),
        .edge_i   (edge_q),
        .evt_o    (line_evt)
    );

    gpio_irq_router #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_router (
        .evt_i (line_evt),
        .off_i (route_off),
        .idx_i (route_idx_flat),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned N_IRQ   = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [N_LINES-1:0] pad_out,
    input logic [N_LINES-1:0] pad_oe,
    input logic [N_IRQ-1:0]   irq_o,
    input logic [N_LINES-1:0] mask_q,
    input logic [N_LINES-1:0] edge_q,
    input logic [N_LINES-1:0] sync_now,
    input logic [N_LINES-1:0] sync_old,
    input logic [N_LINES-1:0] line_evt
);
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8)) |=> (pad_oe == $past(bus_wdata[N_LINES-1:0]))); // R3

    AST_OUT_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(4)) |=> (pad_out == $past(bus_wdata[N_LINES-1:0]))); // R3

    AST_EDGE_STEADY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((&edge_q) && (sync_now == sync_old)) |-> (irq_o == '0)); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (irq_o == '0)); // R8

    AST_WIRE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt == '0) |-> (irq_o == '0)); // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .N_LINES(N_LINES), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .edge_q    (edge_q),
    .sync_now  (sync_now),
    .sync_old  (sync_old),
    .line_evt  (line_evt)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
    localparam int NL = 8;
    localparam int NI = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out, pad_oe;
    logic [NI-1:0] irq_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [NL-1:0] m_mask, m_pol, m_edge;
    logic [7:0]    m_route [NL];

    always #2.5 clk = ~clk;

    gpio_irq_port #(.N_LINES(NL), .N_IRQ(NI), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    function automatic logic [NI-1:0] exp_irq(input logic [NL-1:0] pv, input logic [NL-1:0] cv);
        logic [NI-1:0] r = '0;
        for (int i = 0; i < NL; i++) begin
            logic ev;
            if (m_edge[i]) ev = (pv[i] != cv[i]) && (cv[i] == m_pol[i]);
            else           ev = (cv[i] == m_pol[i]);
            ev = ev & m_mask[i];
            if (!m_route[i][7] && m_route[i][4:0] < NI) r[m_route[i][4:0]] |= ev;
        end
        return r;
    endfunction

    task automatic apply_cfg(input logic [NL-1:0] mk, input logic [NL-1:0] pl, input logic [NL-1:0] ed);
        m_mask = mk; m_pol = pl; m_edge = ed;
        wr(8'h0C, 32'(mk));
        wr(8'h10, 32'(pl));
        wr(8'h14, 32'(ed));
        for (int w = 0; w < (NL + 3) / 4; w++) begin
            logic [31:0] d = '0;
            for (int b = 0; b < 4; b++)
                if (4 * w + b < NL) d[8*b +: 8] = m_route[4*w+b];
            wr(AW'(32 + 4 * w), d);
        end
    endtask

    task automatic run_vec(input string tag, input logic [NL-1:0] a, input logic [NL-1:0] b);
        @(negedge clk);
        pad_in = a;
        repeat (3) @(negedge clk);
        pad_in = b;
        @(negedge clk);
        @(negedge clk);
        check({tag, " transition cycle"}, 32'(irq_o), 32'(exp_irq(a, b)));
        rd_check("R4 input data", 8'h00, 32'(b));
        @(negedge clk);
        check({tag, " settled"}, 32'(irq_o), 32'(exp_irq(b, b)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) m_route[i] = 8'h80;
        m_mask = '0; m_pol = '0; m_edge = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 pad_out", 32'(pad_out), 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
        rd_check("R1 dir", 8'h08, 32'h0);
        rd_check("R1 mask", 8'h0C, 32'h0);
        rd_check("R1 pol", 8'h10, 32'h0);
        rd_check("R1 edge", 8'h14, 32'h0);
        rd_check("R1 route w0", 8'h20, 32'h80808080);
        rd_check("R1 route w1", 8'h24, 32'h80808080);

        // R2 readback, R3 pad drive
        wr(8'h08, 32'hFFFF_FF0F);
        rd_check("R2 dir readback", 8'h08, 32'h0000_000F);
        wr(8'h18, 32'h1234_5A5A);
        rd_check("R2 hold readback", 8'h18, 32'h0000_005A);
        wr(8'h04, 32'h0000_00A5);
        rd_check("R2 out readback", 8'h04, 32'h0000_00A5);
        check("R3 pad_out", 32'(pad_out), 32'hA5);
        check("R3 pad_oe", 32'(pad_oe), 32'h0F);

        // R4 sync latency and write ignored
        wr(8'h00, 32'hFFFF_FFFF);
        @(negedge clk); pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        rd_check("R4 settled", 8'h00, 32'h3C);
        @(negedge clk); pad_in = 8'hC3;
        @(negedge clk);
        rd_check("R4 one edge", 8'h00, 32'h3C);
        @(negedge clk);
        rd_check("R4 two edges", 8'h00, 32'hC3);

        // directed triggers on line 0 routed to wire 0
        m_route[0] = 8'h00;
        apply_cfg(8'h01, 8'h00, 8'h00);
        run_vec("R5 level low", 8'h01, 8'h00);
        apply_cfg(8'h01, 8'h01, 8'h00);
        run_vec("R6 level high", 8'h00, 8'h01);
        apply_cfg(8'h01, 8'h01, 8'h01);
        run_vec("R7 rise", 8'h00, 8'h01);
        run_vec("R7 fall ignored on rise", 8'h01, 8'h00);
        apply_cfg(8'h01, 8'h00, 8'h01);
        run_vec("R7 fall", 8'h01, 8'h00);
        apply_cfg(8'h00, 8'h01, 8'h00);
        run_vec("R8 disabled", 8'h00, 8'h01);

        // R9 routing: shared wires, unrouted, out-of-range index
        for (int i = 0; i < NL; i++) m_route[i] = 8'(i % 4);
        m_route[5] = 8'h80;
        m_route[6] = 8'h09;
        apply_cfg(8'hFF, 8'hFF, 8'h00);
        run_vec("R9 shared", 8'h00, 8'h60);
        run_vec("R9 shared pair", 8'h00, 8'h11);
        run_vec("R9 all", 8'h00, 8'hFF);
        wr(8'h20, 32'h00E5_0000);
        rd_check("R9 byte layout", 8'h20, 32'h0085_0000);

        // random configurations
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < NL; i++) begin
                if ($urandom % 4 == 0) m_route[i] = 8'h80;
                else                   m_route[i] = 8'($urandom % 6);
            end
            apply_cfg(NL'($urandom), NL'($urandom), NL'($urandom));
            run_vec("R9 random", NL'($urandom), NL'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule